// File: doc/BRIEF.md
# Machine-Mode Control Register File with Timer Trap Entry

This block holds the machine-level control and status registers of a small 32-bit integer core. It has five registers: status, interrupt enable, trap vector base, exception PC and trap cause. It executes the three read-modify-write register instructions: swap, bit set and bit clear. Each of them returns the register's old value in the same cycle, so the core can pick it as a write-back source.

A timer-pending input, gated by the global and timer enable bits, starts trap entry. In the cycle the trap is taken, the block raises a trap flag and puts the handler address on the next-PC output. This overrides the sequential, branch or jump target offered by the core. On the following clock edge, the exception PC, the cause and the status enable bits are all updated together. A trap write beats any register instruction write to the same register in that cycle. A trap-return input restores the interrupt enable bit and steers fetch back to the saved exception PC.

Top module: `mcsr_unit`

## Requirements
- R1: After a clock with `rst_n` low, every register reads zero, `trap_take` is 0 and `next_pc` equals `seq_pc`.
- R2: `csr_rdata` is, in the same cycle, the current value of the register at `csr_addr` (status 0x300, enable 0x304, vector 0x305, exception PC 0x341, cause 0x342), taken before that cycle's write. Any other address reads zero, and writes to it change no register.
- R3: With `csr_en` high and `csr_op` = 01 (swap), the addressed register takes `csr_wdata` at the next edge. This applies to its implemented bits only, as given in R5.
- R4: With `csr_op` = 10 (set), the operand's one-bits are ORed into the register. With `csr_op` = 11 (clear), they are cleared from it. With a zero operand, neither form writes. `csr_op` = 00 never writes.
- R5: In the status register only bit 3 (interrupt enable) and bit 7 (previous enable) exist. In the enable register only bit 7 (timer enable) exists. Bits 1:0 of the vector and exception-PC registers read zero. The cause register keeps all 32 bits.
- R6: `trap_take` is high in the same cycle exactly when status bit 3, enable bit 7 and `timer_pend` are all 1.
- R7: At the edge that ends a `trap_take` cycle, these updates happen together: the exception PC takes `pc_cur` with bits 1:0 cleared, the cause takes 0x80000007, status bit 7 takes the old bit 3, and status bit 3 clears.
- R8: In a trap cycle, the trap writes win over a register instruction write to the status, exception-PC or cause register. A same-cycle instruction write to the enable or vector register still takes effect.
- R9: `next_pc` is the vector base (bits 1:0 zero) when `trap_take` is high. Otherwise it is the exception PC when `mret` is high. Otherwise it is `seq_pc`.
- R10: `mret` without a trap sets status bit 3 from the old bit 7 and sets bit 7 to 1. It beats a same-cycle instruction write to the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_en | input | 1 | Register instruction valid |
| csr_addr | input | 12 | Register address |
| csr_op | input | 2 | 00 none, 01 swap, 10 set, 11 clear |
| csr_wdata | input | 32 | Source operand |
| csr_rdata | output | 32 | Old value of the addressed register |
| timer_pend | input | 1 | Timer interrupt pending |
| mret | input | 1 | Trap return in this cycle |
| pc_cur | input | 32 | Address of the instruction in the trap slot |
| seq_pc | input | 32 | Next PC chosen by the core |
| trap_take | output | 1 | Trap entry in this cycle |
| next_pc | output | 32 | Fetch address after priority selection |

## Verification
The assertions take three things for granted. All inputs are known from the first clock on. `rst_n` is held low for at least one edge before use. A trap-return and a trap may coincide only in the way R9 and R10 order them. The stimulus changes every input just after the falling edge. It holds reset for two edges. It samples combinational outputs a nanosecond later and register effects by reading them back on a later cycle. Register instruction, timer and return inputs are driven together only in the cycles that test R8, R9 and R10.

// File: rtl/mcsr_pkg.sv
// Shared constants for the machine-mode register file: register addresses,
// operation codes, status bit positions and the timer cause value.
package mcsr_pkg;
    localparam int XLEN = 32;

    localparam logic [11:0] ADR_STATUS = 12'h300;
    localparam logic [11:0] ADR_ENABLE = 12'h304;
    localparam logic [11:0] ADR_VECTOR = 12'h305;
    localparam logic [11:0] ADR_EPC    = 12'h341;
    localparam logic [11:0] ADR_CAUSE  = 12'h342;

    localparam logic [1:0] OP_NONE = 2'b00;
    localparam logic [1:0] OP_SWAP = 2'b01;
    localparam logic [1:0] OP_SET  = 2'b10;
    localparam logic [1:0] OP_CLR  = 2'b11;

    localparam int GIE_BIT  = 3;   // global interrupt enable in status
    localparam int PGIE_BIT = 7;   // previous enable in status
    localparam int TIE_BIT  = 7;   // timer enable in enable register

    localparam logic [XLEN-1:0] TIMER_CAUSE = {1'b1, {(XLEN-4){1'b0}}, 3'd7};
endpackage

// File: rtl/mcsr_rmw.sv
// Read-modify-write datapath. Computes the new register value from the old
// value and the operand, and decides whether a write happens.
// Assumes the old value is the registered content, with no forwarding.
module mcsr_rmw
    import mcsr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         en,
    input  logic [1:0]   op,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] operand,
    output logic [W-1:0] new_val,
    output logic         wr_req
);
    logic nonzero;

    // Select the combined value for the requested operation
    always_comb begin
        nonzero = |operand;
        new_val = old_val;
        wr_req  = 1'b0;
        case (op)
            OP_SWAP: begin
                new_val = operand;
                wr_req  = en;
            end
            OP_SET: begin
                new_val = old_val | operand;
                wr_req  = en & nonzero;
            end
            OP_CLR: begin
                new_val = old_val & ~operand;
                wr_req  = en & nonzero;
            end
            default: begin
                new_val = old_val;
                wr_req  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mcsr_regs.sv
// Register storage with write priority: trap entry, then trap return, then
// instruction write. Provides the read mux and the fields the trap logic and
// next-PC selection need. Assumes at most one instruction write per cycle.
module mcsr_regs
    import mcsr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [11:0]  addr,
    input  logic         wr_req,
    input  logic [W-1:0] new_val,
    input  logic         trap_take,
    input  logic         mret,
    input  logic [W-1:0] trap_pc,
    output logic [W-1:0] rdata,
    output logic         gie,
    output logic         tie,
    output logic [W-1:0] vector_q,
    output logic [W-1:0] epc_q
);
    localparam logic [W-1:0] ALIGN_MASK  = ~W'(3);
    localparam logic [W-1:0] STATUS_MASK = (W'(1) << GIE_BIT) | (W'(1) << PGIE_BIT);
    localparam logic [W-1:0] ENABLE_MASK = W'(1) << TIE_BIT;

    logic [W-1:0] status_q, enable_q, cause_q;
    logic hit_status, hit_enable, hit_vector, hit_epc, hit_cause;

    // Address decode
    always_comb begin
        hit_status = (addr == ADR_STATUS);
        hit_enable = (addr == ADR_ENABLE);
        hit_vector = (addr == ADR_VECTOR);
        hit_epc    = (addr == ADR_EPC);
        hit_cause  = (addr == ADR_CAUSE);
    end

    // Read mux returning the pre-write value, zero when unmapped
    always_comb begin
        rdata = '0;
        if (hit_status) rdata = status_q;
        if (hit_enable) rdata = enable_q;
        if (hit_vector) rdata = vector_q;
        if (hit_epc)    rdata = epc_q;
        if (hit_cause)  rdata = cause_q;
    end

    // Status: trap entry beats return, return beats instruction write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (trap_take) begin
            status_q[PGIE_BIT] <= status_q[GIE_BIT];
            status_q[GIE_BIT]  <= 1'b0;
        end else if (mret) begin
            status_q[GIE_BIT]  <= status_q[PGIE_BIT];
            status_q[PGIE_BIT] <= 1'b1;
        end else if (wr_req && hit_status) begin
            status_q <= new_val & STATUS_MASK;
        end
    end

    // Enable and vector registers, written only by instructions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            vector_q <= '0;
        end else begin
            if (wr_req && hit_enable) enable_q <= new_val & ENABLE_MASK;
            if (wr_req && hit_vector) vector_q <= new_val & ALIGN_MASK;
        end
    end

    // Exception PC and cause: trap entry wins over instruction writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (trap_take) begin
            epc_q   <= trap_pc & ALIGN_MASK;
            cause_q <= TIMER_CAUSE;
        end else begin
            if (wr_req && hit_epc)   epc_q   <= new_val & ALIGN_MASK;
            if (wr_req && hit_cause) cause_q <= new_val;
        end
    end

    assign gie = status_q[GIE_BIT];
    assign tie = enable_q[TIE_BIT];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && enable_q == '0 && vector_q == '0 && epc_q == '0 && cause_q == '0));
    // R7
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> cause_q == TIMER_CAUSE);
    // R7
    trap_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (!status_q[GIE_BIT] && status_q[PGIE_BIT] == $past(status_q[GIE_BIT])));
    // R7
    trap_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> epc_q == ($past(trap_pc) & ALIGN_MASK));
    // R10
    mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && !trap_take) |=> (status_q[PGIE_BIT] && status_q[GIE_BIT] == $past(status_q[PGIE_BIT])));
    // R5
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~STATUS_MASK) == '0 && (enable_q & ~ENABLE_MASK) == '0);
endmodule

// File: rtl/mcsr_pcsel.sv
// Next-PC priority: taken trap, then trap return, then the core's choice.
// Assumes the vector and exception-PC inputs are already aligned.
module mcsr_pcsel #(
    parameter int W = 32
) (
    input  logic         trap_take,
    input  logic         mret,
    input  logic [W-1:0] vector_q,
    input  logic [W-1:0] epc_q,
    input  logic [W-1:0] seq_pc,
    output logic [W-1:0] next_pc
);
    // Priority selection of the fetch address
    always_comb begin
        if (trap_take)  next_pc = vector_q;
        else if (mret)  next_pc = epc_q;
        else            next_pc = seq_pc;
    end
endmodule

// File: rtl/mcsr_unit.sv
// Top of the machine-mode register file. Joins the read-modify-write path,
// the register storage, trap gating and next-PC selection. Assumes the core
// discards the instruction in the slot whenever trap_take is high.
module mcsr_unit
    import mcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_en,
    input  logic [11:0] csr_addr,
    input  logic [1:0]  csr_op,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        timer_pend,
    input  logic        mret,
    input  logic [31:0] pc_cur,
    input  logic [31:0] seq_pc,
    output logic        trap_take,
    output logic [31:0] next_pc
);
    logic [31:0] new_val, vector_q, epc_q;
    logic        wr_req, gie, tie;

    mcsr_rmw #(.W(32)) u_rmw (
        .en(csr_en), .op(csr_op), .old_val(csr_rdata), .operand(csr_wdata),
        .new_val(new_val), .wr_req(wr_req)
    );

    mcsr_regs #(.W(32)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(csr_addr), .wr_req(wr_req),
        .new_val(new_val), .trap_take(trap_take), .mret(mret),
        .trap_pc(pc_cur), .rdata(csr_rdata), .gie(gie), .tie(tie),
        .vector_q(vector_q), .epc_q(epc_q)
    );

    // Timer trap gating by both enables
    always_comb trap_take = gie & tie & timer_pend;

    mcsr_pcsel #(.W(32)) u_pcsel (
        .trap_take(trap_take), .mret(mret), .vector_q(vector_q),
        .epc_q(epc_q), .seq_pc(seq_pc), .next_pc(next_pc)
    );

    // R6
    trap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !trap_take);
    // R4
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_op[1] && csr_wdata == '0 && !trap_take && !mret)
        |=> ($stable(vector_q) && $stable(epc_q) && $stable(gie) && $stable(tie)));
    // R9
    trap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> next_pc[1:0] == 2'b00);
endmodule

// File: tb/mcsr_unit_test.sv
`timescale 1ns/1ps
module mcsr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_en = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        timer_pend = 1'b0;
    logic        mret = 1'b0;
    logic [31:0] pc_cur = '0;
    logic [31:0] seq_pc = 32'h0000_0040;
    logic        trap_take;
    logic [31:0] next_pc;

    int total = 0;
    int bad = 0;
    logic [31:0] s_rd, s_np;
    logic        s_tt;

    localparam logic [11:0] A_ST = 12'h300, A_EN = 12'h304, A_VEC = 12'h305,
                            A_EPC = 12'h341, A_CAU = 12'h342, A_BAD = 12'h7C0;
    localparam logic [31:0] SEQ = 32'h0000_0040;

    mcsr_unit uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, combinational outputs sampled 1 ns later
    task automatic cyc(input logic en, input logic [11:0] a, input logic [1:0] op,
                       input logic [31:0] d, input logic tp, input logic mr,
                       input logic [31:0] pc);
        @(negedge clk);
        csr_en = en; csr_addr = a; csr_op = op; csr_wdata = d;
        timer_pend = tp; mret = mr; pc_cur = pc; seq_pc = SEQ;
        #1;
        s_rd = csr_rdata; s_tt = trap_take; s_np = next_pc;
    endtask

    task automatic rd(input logic [11:0] a);
        cyc(1'b1, a, 2'b00, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] op, input logic [31:0] d);
        cyc(1'b1, a, op, d, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_reset();
        rd(A_ST);  chk("R1 status", s_rd, 0);
        chk("R1 trap_take", {31'b0, s_tt}, 0);
        chk("R1 next_pc", s_np, SEQ);
        rd(A_EN);  chk("R1 enable", s_rd, 0);
        rd(A_VEC); chk("R1 vector", s_rd, 0);
        rd(A_EPC); chk("R1 epc", s_rd, 0);
        rd(A_CAU); chk("R1 cause", s_rd, 0);
    endtask

    task automatic t_swap();
        wr(A_VEC, 2'b01, 32'h1000_0103); chk("R2 old vector", s_rd, 0);
        rd(A_VEC); chk("R3 R5 vector", s_rd, 32'h1000_0100);
        wr(A_ST, 2'b01, 32'hFFFF_FFFF);
        rd(A_ST);  chk("R5 status bits", s_rd, 32'h88);
        wr(A_ST, 2'b01, 32'h0);
        wr(A_EN, 2'b01, 32'hFFFF_FFFF);
        rd(A_EN);  chk("R5 enable bits", s_rd, 32'h80);
        wr(A_EN, 2'b01, 32'h0);
        wr(A_CAU, 2'b01, 32'h1234_5678);
        wr(A_CAU, 2'b01, 32'h0000_00F0); chk("R2 swap old", s_rd, 32'h1234_5678);
        rd(A_CAU); chk("R3 cause", s_rd, 32'hF0);
        wr(A_BAD, 2'b01, 32'hDEAD_BEEF); chk("R2 unmapped read", s_rd, 0);
        rd(A_BAD); chk("R2 unmapped after write", s_rd, 0);
        rd(A_CAU); chk("R2 unmapped no side effect", s_rd, 32'hF0);
        wr(A_CAU, 2'b00, 32'hFFFF_FFFF);
        rd(A_CAU); chk("R4 op none", s_rd, 32'hF0);
    endtask

    task automatic t_setclr();
        wr(A_CAU, 2'b10, 32'h0F); chk("R4 set old", s_rd, 32'hF0);
        rd(A_CAU); chk("R4 set", s_rd, 32'hFF);
        wr(A_CAU, 2'b11, 32'h3C); chk("R4 clear old", s_rd, 32'hFF);
        rd(A_CAU); chk("R4 clear", s_rd, 32'hC3);
        wr(A_CAU, 2'b10, 32'h0);
        rd(A_CAU); chk("R4 set zero", s_rd, 32'hC3);
        wr(A_CAU, 2'b11, 32'h0);
        rd(A_CAU); chk("R4 clear zero", s_rd, 32'hC3);
        wr(A_CAU, 2'b01, 32'h0);
        rd(A_CAU); chk("R4 swap zero writes", s_rd, 0);
    endtask

    task automatic t_gate();
        wr(A_VEC, 2'b01, 32'h0000_0200);
        wr(A_ST, 2'b01, 32'h08);
        cyc(1'b0, 12'h0, 2'b00, 0, 1'b1, 1'b0, 32'h500);
        chk("R6 no trap without timer enable", {31'b0, s_tt}, 0);
        chk("R9 seq when idle", s_np, SEQ);
        wr(A_ST, 2'b01, 32'h0);
        wr(A_EN, 2'b01, 32'h80);
        cyc(1'b0, 12'h0, 2'b00, 0, 1'b1, 1'b0, 32'h500);
        chk("R6 no trap without global enable", {31'b0, s_tt}, 0);
        wr(A_ST, 2'b01, 32'h08);
        cyc(1'b0, 12'h0, 2'b00, 0, 1'b0, 1'b0, 32'h500);
        chk("R6 no trap without pending", {31'b0, s_tt}, 0);
    endtask

    task automatic t_trap();
        cyc(1'b0, 12'h0, 2'b00, 0, 1'b1, 1'b0, 32'h0000_1236);
        chk("R6 trap taken", {31'b0, s_tt}, 1);
        chk("R9 trap target", s_np, 32'h200);
        cyc(1'b0, 12'h0, 2'b00, 0, 1'b1, 1'b0, 32'h0000_1300);
        chk("R6 no retrap after entry", {31'b0, s_tt}, 0);
        rd(A_EPC); chk("R7 epc", s_rd, 32'h1234);
        rd(A_CAU); chk("R7 cause", s_rd, 32'h8000_0007);
        rd(A_ST);  chk("R7 status", s_rd, 32'h80);
    endtask

    task automatic t_mret();
        cyc(1'b1, A_ST, 2'b01, 32'h0, 1'b0, 1'b1, 32'h0);
        chk("R9 mret target", s_np, 32'h1234);
        chk("R9 mret no trap", {31'b0, s_tt}, 0);
        rd(A_ST);  chk("R10 mret restore beats write", s_rd, 32'h88);
        cyc(1'b0, 12'h0, 2'b00, 0, 1'b1, 1'b1, 32'h0000_2000);
        chk("R9 trap beats mret", s_np, 32'h200);
        rd(A_ST);  chk("R10 trap beats mret status", s_rd, 32'h80);
        rd(A_EPC); chk("R7 epc second trap", s_rd, 32'h2000);
    endtask

    task automatic t_prio();
        wr(A_ST, 2'b01, 32'h08);
        cyc(1'b1, A_CAU, 2'b01, 32'h55, 1'b1, 1'b0, 32'h0000_3000);
        chk("R8 trap with cause write", {31'b0, s_tt}, 1);
        rd(A_CAU); chk("R8 trap wins cause", s_rd, 32'h8000_0007);
        wr(A_ST, 2'b01, 32'h08);
        cyc(1'b1, A_EPC, 2'b01, 32'h44, 1'b1, 1'b0, 32'h0000_3100);
        rd(A_EPC); chk("R8 trap wins epc", s_rd, 32'h3100);
        wr(A_ST, 2'b01, 32'h08);
        cyc(1'b1, A_ST, 2'b01, 32'h08, 1'b1, 1'b0, 32'h0000_3200);
        rd(A_ST);  chk("R8 trap wins status", s_rd, 32'h80);
        wr(A_ST, 2'b01, 32'h08);
        cyc(1'b1, A_VEC, 2'b01, 32'h400, 1'b1, 1'b0, 32'h0000_3300);
        rd(A_VEC); chk("R8 vector write proceeds", s_rd, 32'h400);
        wr(A_ST, 2'b01, 32'h08);
        cyc(1'b1, A_EN, 2'b01, 32'h0, 1'b1, 1'b0, 32'h0000_3400);
        chk("R8 trap taken with enable write", {31'b0, s_tt}, 1);
        rd(A_EN);  chk("R8 enable write proceeds", s_rd, 0);
    endtask

    initial begin
        fork
            begin
                repeat (2) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_swap();
                t_setclr();
                t_gate();
                t_trap();
                t_mret();
                t_prio();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule